// File: doc/BRIEF.md
# Privilege-Checked Segment Address Decoder

This block takes a 32-bit virtual address together with the current privilege mode and access kind, and decides where the address lands. The address space is split by its top bits into five windows. Two kernel windows are unmapped and translate by dropping a fixed base. Three windows are mapped, and for those the block takes the outcome of an external TLB lookup. That outcome arrives on the same cycle as the request. The lower half of the address space is the user window. While the error-level bit is set, it becomes an identity map that ignores the TLB.

A request is accepted on any cycle where `req_vld_i` is high. One clock later the response appears, with either a physical address or a fault flag and a 5-bit exception class. On a fault the block also records the failing address in three capture registers: a bad-address copy, a context word that holds the page-pair number under a table base, and an entry-high word that holds the page-pair number above the current ASID. Other logic reads these registers to service the miss.

Top module: `seg_xlate_unit`

## Requirements
- R1: With `erl_i`=0, an address with bit 31 clear is mapped in every mode; when the TLB reports a hit (`tlb_res_i`=0) the response carries `pa_o`=`tlb_pa_i` and no fault.
- R2: With `erl_i`=1, an address with bit 31 clear gives `pa_o` equal to the address and no fault, whatever `tlb_res_i` holds.
- R3: Addresses 0x80000000..0x9FFFFFFF are usable only in kernel mode and give `pa_o` = address − 0x80000000.
- R4: Addresses 0xA0000000..0xBFFFFFFF are usable only in kernel mode and give `pa_o` = address − 0xA0000000.
- R5: Addresses 0xC0000000..0xDFFFFFFF are mapped and usable in supervisor (`mode_i`=1) or kernel mode; user mode (`mode_i`=2) faults.
- R6: Addresses 0xE0000000..0xFFFFFFFF are mapped and usable only in kernel mode.
- R7: Kernel mode is any `mode_i` other than 1 or 2, so both 0 and 3 are kernel.
- R8: A privilege violation faults with code 5 for stores (`acc_i`=1) and 4 for loads and fetches, and the TLB outcome is ignored.
- R9: A TLB miss (`tlb_res_i`=1) or invalid entry (2) faults with code 3 for stores and 2 otherwise; `refill_o` is set only for a miss.
- R10: A dirty-entry fault (`tlb_res_i`=3) gives code 1.
- R11: A read-inhibit fault (4) gives code 19 and an execute-inhibit fault (5) gives code 20 when `iec_i`=1; with `iec_i`=0 both give code 2.
- R12: `inst_na_o` is set on a faulting fetch (`acc_i`=2) and clear otherwise; a faulting response drives `pa_o` to zero.
- R13: On a fault, `badvaddr_o` takes the address, `context_o` becomes {`ctx_base_i`, address[31:13], 4'b0000} and `entryhi_o` becomes {address[31:13], zeros, `asid_i`}; without a fault all three keep their values.
- R14: Reset clears every output, and `rsp_vld_o` follows `req_vld_i` by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld_i | input | 1 | Request strobe |
| va_i | input | 32 | Virtual address |
| acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| mode_i | input | 2 | Privilege: 1 supervisor, 2 user, other kernel |
| erl_i | input | 1 | Error level, identity-maps the user window |
| iec_i | input | 1 | Selects distinct inhibit exception codes |
| tlb_res_i | input | 3 | TLB outcome: 0 hit, 1 miss, 2 invalid, 3 dirty, 4 read-inhibit, 5 execute-inhibit |
| tlb_pa_i | input | 32 | Physical address from the TLB on a hit |
| asid_i | input | ASID_W | Current address-space identifier |
| ctx_base_i | input | 9 | Page-table base placed above the context page number |
| rsp_vld_o | output | 1 | Response strobe |
| pa_o | output | 32 | Physical address, zero on a fault |
| fault_o | output | 1 | Translation failed |
| exc_code_o | output | 5 | Exception class |
| refill_o | output | 1 | Fault was a TLB miss |
| inst_na_o | output | 1 | Fault happened on a fetch |
| badvaddr_o | output | 32 | Last faulting address |
| context_o | output | 32 | Table base with faulting page number |
| entryhi_o | output | 32 | Faulting page number with ASID |

## Verification
The bench probes the window edges (0x7FFFFFFF, 0x80000000, 0x9FFFFFFF, 0xA0000000, 0xC0000000, 0xE0000000) across all four mode encodings. A decoder that slices the wrong address bits or forgets that mode 3 is kernel would misroute or falsely fault there. It pairs the error-level override with a TLB miss, so a design that still consults the TLB would fault. It also sends a bad-address access with a TLB hit present, which a design that lets the TLB outcome win would pass. Each inhibit fault is run with the enable both high and low, and miss and invalid are run side by side to catch a stray refill flag. After a fault, a clean access follows, so that capture registers overwritten on success show up as miscompares.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int ADDR_W     = 32;
    localparam int VPN2_LSB   = 13;
    localparam int VPN2_W     = ADDR_W - VPN2_LSB;
    localparam int CTX_LSB    = 4;
    localparam int CTX_BASE_W = ADDR_W - VPN2_W - CTX_LSB;
    localparam int CODE_W     = 5;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        MODE_KERN  = 2'd0,
        MODE_SUPER = 2'd1,
        MODE_USER  = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        TLB_HIT     = 3'd0,
        TLB_MISS    = 3'd1,
        TLB_INVALID = 3'd2,
        TLB_DIRTY   = 3'd3,
        TLB_RDINH   = 3'd4,
        TLB_EXINH   = 3'd5
    } tlb_res_e;

    typedef enum logic [2:0] {
        WIN_USER,
        WIN_KDIR0,
        WIN_KDIR1,
        WIN_SUPMAP,
        WIN_KMAP
    } win_e;

    localparam logic [CODE_W-1:0] EXC_NONE  = 5'd0;
    localparam logic [CODE_W-1:0] EXC_MOD   = 5'd1;
    localparam logic [CODE_W-1:0] EXC_TLBL  = 5'd2;
    localparam logic [CODE_W-1:0] EXC_TLBS  = 5'd3;
    localparam logic [CODE_W-1:0] EXC_ADEL  = 5'd4;
    localparam logic [CODE_W-1:0] EXC_ADES  = 5'd5;
    localparam logic [CODE_W-1:0] EXC_TLBRI = 5'd19;
    localparam logic [CODE_W-1:0] EXC_TLBXI = 5'd20;

    localparam logic [ADDR_W-1:0] KDIR0_BASE = 32'h8000_0000;
    localparam logic [ADDR_W-1:0] KDIR1_BASE = 32'hA000_0000;

    typedef struct packed {
        logic                  fault;
        logic [CODE_W-1:0]     code;
        logic                  refill;
        logic                  inst_na;
        logic [ADDR_W-1:0]     pa;
    } xlate_s;

    typedef struct packed {
        win_e                  win;
        logic                  mapped;
        logic                  bad;
        logic [ADDR_W-1:0]     direct_pa;
    } route_s;

    function automatic logic is_kernel(input mode_e m);
        return !(m == MODE_USER || m == MODE_SUPER);
    endfunction

    function automatic logic [CODE_W-1:0] tlb_code(input tlb_res_e r,
                                                   input acc_e a,
                                                   input logic iec);
        logic [CODE_W-1:0] c;
        case (r)
            TLB_MISS,
            TLB_INVALID: c = (a == ACC_STORE) ? EXC_TLBS : EXC_TLBL;
            TLB_DIRTY:   c = EXC_MOD;
            TLB_RDINH:   c = iec ? EXC_TLBRI : EXC_TLBL;
            TLB_EXINH:   c = iec ? EXC_TLBXI : EXC_TLBL;
            default:     c = EXC_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/seg_classify.sv
module seg_classify
    import seg_pkg::*;
(
    input  logic [ADDR_W-1:0] va,
    input  mode_e             mode,
    input  logic              erl,
    output route_s            route
);
    logic kern;

    always_comb begin
        kern            = is_kernel(mode);
        route.win       = WIN_USER;
        route.mapped    = 1'b0;
        route.bad       = 1'b0;
        route.direct_pa = '0;
        if (!va[ADDR_W-1]) begin
            route.win = WIN_USER;
            if (erl) begin
                route.direct_pa = va;
            end else begin
                route.mapped = 1'b1;
            end
        end else begin
            case (va[ADDR_W-2:ADDR_W-3])
                2'b00: begin
                    route.win       = WIN_KDIR0;
                    route.bad       = !kern;
                    route.direct_pa = va - KDIR0_BASE;
                end
                2'b01: begin
                    route.win       = WIN_KDIR1;
                    route.bad       = !kern;
                    route.direct_pa = va - KDIR1_BASE;
                end
                2'b10: begin
                    route.win    = WIN_SUPMAP;
                    route.bad    = (mode == MODE_USER);
                    route.mapped = (mode != MODE_USER);
                end
                default: begin
                    route.win    = WIN_KMAP;
                    route.bad    = !kern;
                    route.mapped = kern;
                end
            endcase
        end
    end
endmodule

// File: rtl/seg_fault_map.sv
module seg_fault_map
    import seg_pkg::*;
(
    input  route_s            route,
    input  acc_e              acc,
    input  logic              iec,
    input  tlb_res_e          tlb_res,
    input  logic [ADDR_W-1:0] tlb_pa,
    output xlate_s            res
);
    always_comb begin
        res         = '0;
        if (route.bad) begin
            res.fault = 1'b1;
            res.code  = (acc == ACC_STORE) ? EXC_ADES : EXC_ADEL;
        end else if (route.mapped) begin
            if (tlb_res == TLB_HIT) begin
                res.pa = tlb_pa;
            end else begin
                res.fault  = 1'b1;
                res.code   = tlb_code(tlb_res, acc, iec);
                res.refill = (tlb_res == TLB_MISS);
            end
        end else begin
            res.pa = route.direct_pa;
        end
        res.inst_na = res.fault && (acc == ACC_FETCH);
    end
endmodule

// File: rtl/seg_fault_capture.sv
module seg_fault_capture
    import seg_pkg::*;
#(
    parameter int ASID_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  take,
    input  logic [ADDR_W-1:0]     va,
    input  logic [ASID_W-1:0]     asid,
    input  logic [CTX_BASE_W-1:0] ctx_base,
    output logic [ADDR_W-1:0]     badvaddr,
    output logic [ADDR_W-1:0]     context_w,
    output logic [ADDR_W-1:0]     entryhi
);
    localparam int PAD_W = ADDR_W - VPN2_W - ASID_W;

    logic [VPN2_W-1:0] vpn2;
    assign vpn2 = va[ADDR_W-1:VPN2_LSB];

    always_ff @(posedge clk) begin
        if (rst) begin
            badvaddr  <= '0;
            context_w <= '0;
            entryhi   <= '0;
        end else if (take) begin
            badvaddr  <= va;
            context_w <= {ctx_base, vpn2, {CTX_LSB{1'b0}}};
            entryhi   <= {vpn2, {PAD_W{1'b0}}, asid};
        end
    end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_pkg::*;
#(
    parameter int ASID_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_vld_i,
    input  logic [ADDR_W-1:0]     va_i,
    input  logic [1:0]            acc_i,
    input  logic [1:0]            mode_i,
    input  logic                  erl_i,
    input  logic                  iec_i,
    input  logic [2:0]            tlb_res_i,
    input  logic [ADDR_W-1:0]     tlb_pa_i,
    input  logic [ASID_W-1:0]     asid_i,
    input  logic [CTX_BASE_W-1:0] ctx_base_i,
    output logic                  rsp_vld_o,
    output logic [ADDR_W-1:0]     pa_o,
    output logic                  fault_o,
    output logic [CODE_W-1:0]     exc_code_o,
    output logic                  refill_o,
    output logic                  inst_na_o,
    output logic [ADDR_W-1:0]     badvaddr_o,
    output logic [ADDR_W-1:0]     context_o,
    output logic [ADDR_W-1:0]     entryhi_o
);
    route_s route;
    xlate_s nxt;
    xlate_s rsp_q;
    logic   vld_q;

    seg_classify u_classify (
        .va    (va_i),
        .mode  (mode_e'(mode_i)),
        .erl   (erl_i),
        .route (route)
    );

    seg_fault_map u_fault_map (
        .route   (route),
        .acc     (acc_e'(acc_i)),
        .iec     (iec_i),
        .tlb_res (tlb_res_e'(tlb_res_i)),
        .tlb_pa  (tlb_pa_i),
        .res     (nxt)
    );

    seg_fault_capture #(.ASID_W(ASID_W)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .take      (req_vld_i && nxt.fault),
        .va        (va_i),
        .asid      (asid_i),
        .ctx_base  (ctx_base_i),
        .badvaddr  (badvaddr_o),
        .context_w (context_o),
        .entryhi   (entryhi_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            rsp_q <= '0;
        end else begin
            vld_q <= req_vld_i;
            if (req_vld_i) begin
                rsp_q <= nxt;
            end
        end
    end

    assign rsp_vld_o  = vld_q;
    assign pa_o       = rsp_q.pa;
    assign fault_o    = rsp_q.fault;
    assign exc_code_o = rsp_q.code;
    assign refill_o   = rsp_q.refill;
    assign inst_na_o  = rsp_q.inst_na;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_vld_i,
    input logic [31:0] va_i,
    input logic        erl_i,
    input logic        rsp_vld_o,
    input logic        fault_o,
    input logic [4:0]  exc_code_o,
    input logic        refill_o,
    input logic        inst_na_o,
    input logic [31:0] badvaddr_o
);
    // R14
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_vld_o == $past(req_vld_i));

    // R2
    erl_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(req_vld_i) && $past(erl_i) && !$past(va_i[31])) |-> !fault_o);

    // R13
    bad_addr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld_o && fault_o) |-> badvaddr_o == $past(va_i));

    // R13
    bad_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_vld_o && fault_o) |-> $stable(badvaddr_o));

    // R9
    refill_code_chk: assert property (@(posedge clk) disable iff (rst)
        refill_o |-> (fault_o && (exc_code_o == 5'd2 || exc_code_o == 5'd3)));

    // R12
    inst_na_fault_chk: assert property (@(posedge clk) disable iff (rst)
        inst_na_o |-> fault_o);
endmodule

bind seg_xlate_unit seg_xlate_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_vld_i  (req_vld_i),
    .va_i       (va_i),
    .erl_i      (erl_i),
    .rsp_vld_o  (rsp_vld_o),
    .fault_o    (fault_o),
    .exc_code_o (exc_code_o),
    .refill_o   (refill_o),
    .inst_na_o  (inst_na_o),
    .badvaddr_o (badvaddr_o)
);

// File: tb/seg_xlate_unit_tb_top.sv
module seg_xlate_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld_i = 1'b0;
    logic [31:0] va_i = '0;
    logic [1:0]  acc_i = '0;
    logic [1:0]  mode_i = '0;
    logic        erl_i = 1'b0;
    logic        iec_i = 1'b0;
    logic [2:0]  tlb_res_i = '0;
    logic [31:0] tlb_pa_i = '0;
    logic [7:0]  asid_i = '0;
    logic [8:0]  ctx_base_i = '0;
    logic        rsp_vld_o;
    logic [31:0] pa_o;
    logic        fault_o;
    logic [4:0]  exc_code_o;
    logic        refill_o;
    logic        inst_na_o;
    logic [31:0] badvaddr_o;
    logic [31:0] context_o;
    logic [31:0] entryhi_o;

    always #2.5 clk = ~clk;

    seg_xlate_unit dut_i (.*);

    typedef struct {
        string       tag;
        logic [31:0] pa;
        logic        fault;
        logic [4:0]  code;
        logic        refill;
        logic        ina;
        logic [31:0] bad;
        logic [31:0] ctx;
        logic [31:0] ehi;
    } exp_t;

    exp_t        sb_q[$];
    int          n_vec = 0;
    int          n_err = 0;
    bit          done = 0;
    logic [31:0] m_bad = '0, m_ctx = '0, m_ehi = '0;

    task automatic send(input string tag, input logic [31:0] va, input logic [1:0] acc,
                        input logic [1:0] mode, input logic erl, input logic iec,
                        input logic [2:0] res, input logic [31:0] tpa);
        exp_t e;
        logic kern, mapped, bad;
        logic [31:0] dpa;
        kern = (mode != 2'd1) && (mode != 2'd2);
        mapped = 0; bad = 0; dpa = '0;
        e.tag = tag; e.pa = '0; e.fault = 0; e.code = 0; e.refill = 0;
        if (va < 32'h8000_0000) begin
            if (erl) dpa = va; else mapped = 1;
        end else if (va < 32'hA000_0000) begin
            bad = !kern; dpa = va - 32'h8000_0000;
        end else if (va < 32'hC000_0000) begin
            bad = !kern; dpa = va - 32'hA000_0000;
        end else if (va < 32'hE000_0000) begin
            bad = (mode == 2'd2); mapped = !bad;
        end else begin
            bad = !kern; mapped = kern;
        end
        if (bad) begin
            e.fault = 1; e.code = (acc == 2'd1) ? 5'd5 : 5'd4;
        end else if (mapped) begin
            case (res)
                3'd0: e.pa = tpa;
                3'd1: begin e.fault = 1; e.refill = 1; e.code = (acc == 2'd1) ? 5'd3 : 5'd2; end
                3'd2: begin e.fault = 1; e.code = (acc == 2'd1) ? 5'd3 : 5'd2; end
                3'd3: begin e.fault = 1; e.code = 5'd1; end
                3'd4: begin e.fault = 1; e.code = iec ? 5'd19 : 5'd2; end
                default: begin e.fault = 1; e.code = iec ? 5'd20 : 5'd2; end
            endcase
        end else begin
            e.pa = dpa;
        end
        e.ina = e.fault && (acc == 2'd2);
        if (e.fault) begin
            m_bad = va;
            m_ctx = {ctx_base_i, va[31:13], 4'b0};
            m_ehi = {va[31:13], 5'b0, asid_i};
        end
        e.bad = m_bad; e.ctx = m_ctx; e.ehi = m_ehi;
        va_i = va; acc_i = acc; mode_i = mode; erl_i = erl; iec_i = iec;
        tlb_res_i = res; tlb_pa_i = tpa; req_vld_i = 1'b1;
        sb_q.push_back(e);
        @(negedge clk);
        req_vld_i = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && rsp_vld_o) begin
            exp_t e;
            if (sb_q.size() == 0) begin
                n_err++;
                $display("FAIL R14 unexpected response: actual rsp_vld=1 expected 0");
            end else begin
                e = sb_q.pop_front();
                n_vec++;
                if (pa_o !== e.pa || fault_o !== e.fault || exc_code_o !== e.code ||
                    refill_o !== e.refill || inst_na_o !== e.ina || badvaddr_o !== e.bad ||
                    context_o !== e.ctx || entryhi_o !== e.ehi) begin
                    n_err++;
                    $display("FAIL %s actual pa=%h f=%b c=%0d rf=%b na=%b bad=%h ctx=%h ehi=%h expected pa=%h f=%b c=%0d rf=%b na=%b bad=%h ctx=%h ehi=%h",
                             e.tag, pa_o, fault_o, exc_code_o, refill_o, inst_na_o, badvaddr_o,
                             context_o, entryhi_o, e.pa, e.fault, e.code, e.refill, e.ina,
                             e.bad, e.ctx, e.ehi);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_err++;
        $display("FAIL watchdog expired: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_vec++;
        // R14 reset state
        if (rsp_vld_o !== 0 || pa_o !== 0 || fault_o !== 0 || exc_code_o !== 0 ||
            badvaddr_o !== 0 || context_o !== 0 || entryhi_o !== 0) begin
            n_err++;
            $display("FAIL R14 reset state: actual pa=%h f=%b bad=%h expected all zero",
                     pa_o, fault_o, badvaddr_o);
        end
        asid_i = 8'h5A; ctx_base_i = 9'h1C3;
        send("R1 user hit kernel",     32'h0000_1234, 2'd0, 2'd0, 0, 0, 3'd0, 32'h1111_2000);
        send("R1 user hit user edge",  32'h7FFF_FFFF, 2'd1, 2'd2, 0, 0, 3'd0, 32'h0ABC_DFFF);
        send("R2 erl ignores miss",    32'h4567_89AB, 2'd0, 2'd2, 1, 0, 3'd1, 32'h0);
        send("R3 kdir0 kernel base",   32'h8000_0000, 2'd0, 2'd0, 0, 0, 3'd1, 32'h0);
        send("R3 kdir0 top",           32'h9FFF_FFFC, 2'd2, 2'd0, 0, 0, 3'd0, 32'h0);
        send("R8 kdir0 user load",     32'h8123_4000, 2'd0, 2'd2, 0, 0, 3'd0, 32'hDEAD_0000);
        send("R1 clean after fault",   32'h0000_8000, 2'd0, 2'd0, 0, 0, 3'd0, 32'h0000_8000);
        send("R4 kdir1 kernel",        32'hA000_0010, 2'd1, 2'd0, 0, 0, 3'd0, 32'h0);
        send("R8 kdir1 super store",   32'hBFC0_0000, 2'd1, 2'd1, 0, 0, 3'd0, 32'h0);
        send("R7 mode3 is kernel",     32'hA040_0000, 2'd0, 2'd3, 0, 0, 3'd0, 32'h0);
        send("R5 supmap super hit",    32'hC000_0000, 2'd0, 2'd1, 0, 0, 3'd0, 32'h0222_0000);
        send("R5 supmap user fetch",   32'hD000_1000, 2'd2, 2'd2, 0, 0, 3'd0, 32'h0);
        send("R6 kmap super store",    32'hE000_0000, 2'd1, 2'd1, 0, 0, 3'd0, 32'h0);
        send("R6 kmap kernel hit",     32'hFFFF_F000, 2'd0, 2'd3, 0, 0, 3'd0, 32'h0333_F000);
        send("R9 miss load refill",    32'h0040_2000, 2'd0, 2'd0, 0, 0, 3'd1, 32'h0);
        send("R9 miss store refill",   32'hC123_6000, 2'd1, 2'd0, 0, 0, 3'd1, 32'h0);
        send("R9 invalid load",        32'h1000_0000, 2'd0, 2'd2, 0, 0, 3'd2, 32'h0);
        send("R10 dirty store",        32'hE800_4000, 2'd1, 2'd0, 0, 0, 3'd3, 32'h0);
        send("R11 rdinh iec1",         32'h2000_0000, 2'd0, 2'd0, 0, 1, 3'd4, 32'h0);
        send("R11 rdinh iec0",         32'h2000_2000, 2'd0, 2'd0, 0, 0, 3'd4, 32'h0);
        send("R11 exinh iec1 fetch",   32'h3000_0000, 2'd2, 2'd0, 0, 1, 3'd5, 32'h0);
        send("R11 exinh iec0 fetch",   32'h3000_4000, 2'd2, 2'd0, 0, 0, 3'd5, 32'h0);
        send("R12 fetch miss",         32'h0000_0040, 2'd2, 2'd2, 0, 0, 3'd1, 32'h0);
        send("R13 clean keeps regs",   32'h9000_0000, 2'd0, 2'd0, 0, 0, 3'd0, 32'h0);
        asid_i = 8'hC3; ctx_base_i = 9'h055;
        send("R13 capture new asid",   32'hF00D_E000, 2'd0, 2'd1, 0, 0, 3'd0, 32'h0);
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_err++;
            $display("FAIL R14 missing responses: actual %0d pending expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule